// File: doc/BRIEF.md
# LPC Host SYNC Watchdog

This block sits on the host side of a Low Pin Count bus. It watches the 4-bit address/data nibble while a target fills the SYNC phase of a cycle that the host started. The block sorts every sampled nibble into one of five classes: ready, ready-with-error, short wait, long wait, or invalid. From that sequence it decides whether the cycle completes, completes with an error, or has to be abandoned. The host sequencer pulses `sync_start` when it hands the bus over. It then reacts to the single-cycle verdict pulses, and `data_start_o` tells it that the data nibbles begin.

A cycle can be abandoned for three reasons. The target leaves the bus without a legal SYNC code for too long. The target runs past the allowed number of short waits. Or the target mixes the two kinds of wait code within one cycle. Long waits have no limit. The bus nibble cannot be stalled, so the block has no back-pressure. Every input is consumed in the clock it is present, and every output is a plain pulse.

Top module: `sync_watch`

## Requirements
- R1: After reset, and whenever no cycle is armed, all four outputs stay low. Nibbles on `lad_in` have no effect until `sync_start` is seen while idle. Reset in the middle of a cycle disarms the block.
- R2: The first SYNC nibble is the one on `lad_in` in the clock after `sync_start`. A nibble 4'b0000 produces `done_o` and `data_start_o` high for the following clock only, with `err_o` low.
- R3: A nibble 4'b1001 produces `done_o`, `err_o` and `data_start_o` high together for the following clock only.
- R4: Any nibble other than 0000, 0101, 0110 or 1001 is invalid. Three invalid nibbles in a row (parameter INV_LIMIT) raise `abort_o` in the clock after the third one, with `err_o` low.
- R5: Any valid nibble sets the run of invalid nibbles back to zero, so invalid nibbles that are split up by valid ones never abort the cycle.
- R6: Up to eight (parameter SHORT_CAP) nibbles of 4'b0101 are tolerated in one cycle. The ninth raises `abort_o` in the following clock. Invalid nibbles do not add to this count.
- R7: The nibble 4'b0110 may repeat any number of times without an abort. A later 0000 still completes the cycle.
- R8: A 0101 after a 0110 in the same cycle is a protocol error, and so is a 0110 after a 0101. Either case raises `abort_o` and `err_o` together in the following clock.
- R9: `done_o` and `abort_o` are never high together. Each verdict lasts one clock, after which the block is idle and ignores `lad_in` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_start | input | 1 | Pulse: the SYNC phase begins on the next clock |
| lad_in | input | 4 | Sampled bus nibble |
| done_o | output | 1 | Pulse: SYNC ended with a ready code |
| err_o | output | 1 | Pulse: error code seen or wait kinds mixed |
| abort_o | output | 1 | Pulse: the host must abandon the cycle |
| data_start_o | output | 1 | Pulse: the current clock is the first data clock |

## Verification
The hardest boundary to reach is the short-wait cap. The test needs exactly eight 0101 nibbles followed by a ready code, and a separate case of nine 0101 nibbles in a row. In both, the invalid-run counter has to stay untouched so that the two limits cannot mask each other. The vector table builds these sequences explicitly, and also invalid runs that are broken up by a wait code. A directed test holds 0110 for fifty clocks to show that long waits have no limit. Another directed test resets the block during a short wait and then shows that a ready code is ignored.

// File: rtl/sync_watch_pkg.sv
package sync_watch_pkg;
  localparam logic [3:0] CODE_READY = 4'b0000;
  localparam logic [3:0] CODE_SHORT = 4'b0101;
  localparam logic [3:0] CODE_LONG  = 4'b0110;
  localparam logic [3:0] CODE_ERR   = 4'b1001;

  typedef enum logic [2:0] {
    NIB_READY, NIB_ERR, NIB_SHORT, NIB_LONG, NIB_BAD
  } nib_cls_e;

  typedef enum logic [1:0] {
    WAIT_NONE, WAIT_SHORT, WAIT_LONG
  } wait_mode_e;
endpackage

// File: rtl/sync_nib_decode.sv
module sync_nib_decode
  import sync_watch_pkg::*;
(
  input  logic [3:0] nib,
  output nib_cls_e   cls
);
  always_comb begin
    unique case (nib)
      CODE_READY: cls = NIB_READY;
      CODE_ERR:   cls = NIB_ERR;
      CODE_SHORT: cls = NIB_SHORT;
      CODE_LONG:  cls = NIB_LONG;
      default:    cls = NIB_BAD;
    endcase
  end
endmodule

// File: rtl/sync_run_counter.sv
module sync_run_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sync_watch.sv
module sync_watch
  import sync_watch_pkg::*;
#(
  parameter int INV_LIMIT = 3,
  parameter int SHORT_CAP = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_start,
  input  logic [3:0] lad_in,
  output logic       done_o,
  output logic       err_o,
  output logic       abort_o,
  output logic       data_start_o
);
  localparam int INV_W   = $clog2(INV_LIMIT + 1);
  localparam int SHORT_W = $clog2(SHORT_CAP + 1);
  localparam logic [INV_W-1:0]   INV_LAST  = INV_W'(INV_LIMIT - 1);
  localparam logic [SHORT_W-1:0] SHORT_TOP = SHORT_W'(SHORT_CAP);

  logic               active_q;
  wait_mode_e         mode_q;
  nib_cls_e           cls;
  logic [INV_W-1:0]   inv_cnt;
  logic [SHORT_W-1:0] short_cnt;
  logic fin_done, fin_err, fin_abort;
  logic inv_inc, inv_clr, short_inc, short_clr;

  sync_nib_decode u_dec (.nib(lad_in), .cls(cls));

  sync_run_counter #(.W(INV_W)) u_inv (
    .clk(clk), .rst_n(rst_n), .clr(inv_clr), .inc(inv_inc), .cnt(inv_cnt)
  );

  sync_run_counter #(.W(SHORT_W)) u_short (
    .clk(clk), .rst_n(rst_n), .clr(short_clr), .inc(short_inc), .cnt(short_cnt)
  );

  // counter controls: both counters are held at zero while idle
  assign inv_inc   = active_q && (cls == NIB_BAD);
  assign inv_clr   = !active_q || (cls != NIB_BAD);
  assign short_inc = active_q && (cls == NIB_SHORT) && (mode_q != WAIT_LONG);
  assign short_clr = !active_q;

  // verdict for the nibble sampled in this clock
  always_comb begin
    fin_done  = 1'b0;
    fin_err   = 1'b0;
    fin_abort = 1'b0;
    if (active_q) begin
      unique case (cls)
        NIB_READY: fin_done = 1'b1;
        NIB_ERR: begin
          fin_done = 1'b1;
          fin_err  = 1'b1;
        end
        NIB_SHORT: begin
          if (mode_q == WAIT_LONG) begin
            fin_abort = 1'b1;
            fin_err   = 1'b1;
          end else if (short_cnt == SHORT_TOP) begin
            fin_abort = 1'b1;
          end
        end
        NIB_LONG: begin
          if (mode_q == WAIT_SHORT) begin
            fin_abort = 1'b1;
            fin_err   = 1'b1;
          end
        end
        default: begin
          if (inv_cnt == INV_LAST) fin_abort = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      mode_q       <= WAIT_NONE;
      done_o       <= 1'b0;
      err_o        <= 1'b0;
      abort_o      <= 1'b0;
      data_start_o <= 1'b0;
    end else begin
      done_o       <= fin_done;
      err_o        <= fin_err;
      abort_o      <= fin_abort;
      data_start_o <= fin_done;
      if (!active_q) begin
        if (sync_start) begin
          active_q <= 1'b1;
          mode_q   <= WAIT_NONE;
        end
      end else if (fin_done || fin_abort) begin
        active_q <= 1'b0;
        mode_q   <= WAIT_NONE;
      end else if (cls == NIB_SHORT) begin
        mode_q <= WAIT_SHORT;
      end else if (cls == NIB_LONG) begin
        mode_q <= WAIT_LONG;
      end
    end
  end
endmodule

// File: rtl/sync_watch_chk.sv
module sync_watch_chk #(
  parameter int INV_LIMIT = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_start,
  input logic [3:0] lad_in,
  input logic       done_o,
  input logic       err_o,
  input logic       abort_o,
  input logic       data_start_o
);
  logic       busy_q;
  logic       live;
  logic       bad;
  logic [7:0] inv_run;

  assign live = busy_q && !done_o && !abort_o;
  assign bad  = !(lad_in == 4'b0000 || lad_in == 4'b0101 ||
                  lad_in == 4'b0110 || lad_in == 4'b1001);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      inv_run <= '0;
    end else begin
      busy_q  <= live ? 1'b1 : sync_start;
      inv_run <= (live && bad) ? inv_run + 8'd1 : 8'd0;
    end
  end

  // R1
  verdict_needs_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || abort_o || data_start_o) |-> busy_q);

  // R4
  invalid_run_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && bad && inv_run == 8'(INV_LIMIT - 1)) |=> (abort_o && !err_o));

  // R9
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && abort_o));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |=> !abort_o);

  // R3
  err_with_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (done_o || abort_o));
endmodule

bind sync_watch sync_watch_chk #(.INV_LIMIT(INV_LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_start(sync_start), .lad_in(lad_in),
  .done_o(done_o), .err_o(err_o), .abort_o(abort_o), .data_start_o(data_start_o)
);

// File: tb/sync_watch_tb.sv
`timescale 1ns/1ps
module sync_watch_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_start = 1'b0;
  logic [3:0] lad_in = 4'h0;
  logic       done_o, err_o, abort_o, data_start_o;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  sync_watch u_dut (
    .clk(clk), .rst_n(rst_n), .sync_start(sync_start), .lad_in(lad_in),
    .done_o(done_o), .err_o(err_o), .abort_o(abort_o), .data_start_o(data_start_o)
  );

  // expected outcome {done, err, abort}; data_start follows done
  typedef struct packed {
    logic [47:0] nibs;
    logic [3:0]  len;
    logic [2:0]  res;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{48'h0,          4'd1, 3'b100},  // R2 immediate ready
    '{48'h9,          4'd1, 3'b110},  // R3 error code
    '{48'hFFF,        4'd3, 3'b001},  // R4 three invalid
    '{48'h055,        4'd3, 3'b100},  // R2 after short waits
    '{48'h9666,       4'd4, 3'b110},  // R3 after long waits
    '{48'h033533,     4'd6, 3'b100},  // R5 invalid runs split
    '{48'h65,         4'd2, 3'b011},  // R8 short then long
    '{48'h56,         4'd2, 3'b011},  // R8 long then short
    '{48'hEDC6BA6,    4'd7, 3'b001},  // R5 reset then R4 abort
    '{48'h055555555,  4'd9, 3'b100},  // R6 eight shorts allowed
    '{48'h555555555,  4'd9, 3'b001}   // R6 ninth short aborts
  };

  function automatic logic [3:0] obs();
    return {done_o, err_o, abort_o, data_start_o};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: outputs {done,err,abort,dstart} actual=%b expected=%b", req, act, exp);
    end
  endtask

  // all tasks begin and end at a falling edge
  task automatic arm();
    sync_start = 1'b1;
    @(negedge clk);
    sync_start = 1'b0;
  endtask

  task automatic feed(input logic [3:0] nib);
    lad_in = nib;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state, strobe held during reset
    sync_start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", obs(), 4'b0000);
    sync_start = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", obs(), 4'b0000);

    // R1 idle nibbles ignored
    for (int i = 0; i < 3; i++) begin
      feed(4'h0);
      check("R1 idle ready ignored", obs(), 4'b0000);
    end
    for (int i = 0; i < 4; i++) begin
      feed(4'hF);
      check("R1 idle invalid ignored", obs(), 4'b0000);
    end

    // table walk
    for (int v = 0; v < NV; v++) begin
      arm();
      for (int i = 0; i < int'(VEC[v].len); i++) begin
        feed(VEC[v].nibs[i*4 +: 4]);
        if (i == int'(VEC[v].len) - 1)
          check($sformatf("R2/R3/R4/R5/R6/R8 vector %0d verdict", v), obs(),
                {VEC[v].res, VEC[v].res[2]});
        else
          check($sformatf("R4/R5/R6 vector %0d quiet", v), obs(), 4'b0000);
      end
      feed(4'h0);
      check($sformatf("R9 vector %0d single pulse and idle", v), obs(), 4'b0000);
    end

    // R7 long waits unbounded
    arm();
    for (int i = 0; i < 50; i++) begin
      feed(4'h6);
      check("R7 long wait no abort", obs(), 4'b0000);
    end
    feed(4'h0);
    check("R7 ready after long waits", obs(), 4'b1001);
    feed(4'hF);
    check("R9 idle after long", obs(), 4'b0000);

    // R1 reset mid-cycle disarms
    arm();
    feed(4'h5);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    feed(4'h0);
    check("R1 ready after mid-cycle reset ignored", obs(), 4'b0000);
    for (int i = 0; i < 3; i++) feed(4'hF);
    check("R1 invalid after mid-cycle reset ignored", obs(), 4'b0000);

    // R6 short count does not carry across cycles
    arm();
    for (int i = 0; i < 8; i++) feed(4'h5);
    feed(4'h0);
    check("R6 first cycle eight shorts", obs(), 4'b1001);
    arm();
    for (int i = 0; i < 8; i++) feed(4'h5);
    check("R6 second cycle no carry", obs(), 4'b0000);
    feed(4'h9);
    check("R3 error after shorts", obs(), 4'b1101);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule